// File: doc/BRIEF.md
# Character LCD Handshake Controller

This block sits between a simple user port and a character LCD module. The user hands over one request at a time over a four-phase Strobe/Ready handshake. Each request carries a 2-bit command and an 8-bit character. The block turns every request into one instruction or character write on the display's register-select, enable and data lines. It spaces those lines so that the display can latch them safely, and it holds Ready low until the display has had time to finish the operation.

Everything advances on a single-cycle clock enable, `tick`, which a divider outside the block provides, nominally one pulse every 10 µs. Out of reset the block programs the display with a fixed four-instruction setup before it accepts any user request. The block never reads from the display, so the read/write line is driven low at all times.

Top module: `lcd_handshake_ctrl`

## Requirements
- R1: A request is accepted on the first tick at which `strobe` is sampled high after it was last sampled low while the block was able to take it. `cmd` and `char_in` are captured on that tick.
- R2: `ready` goes low right after the accepting tick. It stays low until the write and its full execution wait are over, and `ready` is never high while `lcd_e` is high.
- R3: Command 2'b00 writes a character: `lcd_rs`=1 and `lcd_db` equals the captured `char_in`.
- R4: Command 2'b01 (clear) writes `lcd_rs`=0 with 8'h01. Command 2'b10 (cursor back one place) writes `lcd_rs`=0 with 8'h10. Command 2'b11 (cursor home) writes `lcd_rs`=0 with 8'h02.
- R5: After reset the block issues four instructions with `lcd_rs`=0, in the order 8'h30, 8'h0C, 8'h06, 8'h01. `ready` rises on tick 188 after reset, given `strobe` low.
- R6: `lcd_e` is a flop output and stays high for exactly one tick. `lcd_rs` and `lcd_db` hold their value for one tick before `lcd_e` rises, while it is high, and for one tick after it falls.
- R7: With `strobe` released during the operation, `ready` comes back on the 8th tick counted from the accepting tick for character and cursor-back requests. It comes back on the 164th tick for clear and home. The wait timer never holds more than 159.
- R8: If `strobe` is still high when the operation ends, `ready` stays low and no further write starts. `ready` rises on the tick after `strobe` is sampled low.
- R9: Changes on `cmd` and `char_in` after the accepting tick do not alter the byte or RS level written.
- R10: `lcd_rw` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle clock enable, one per display time step |
| strobe | input | 1 | User request line of the handshake |
| cmd | input | 2 | Request type: 00 char, 01 clear, 10 back, 11 home |
| char_in | input | 8 | Character code for command 00 |
| ready | output | 1 | High when a new request may be made |
| lcd_rs | output | 1 | Display register select (1 = character data) |
| lcd_e | output | 1 | Display enable strobe |
| lcd_rw | output | 1 | Display read/write, held low |
| lcd_db | output | 8 | Display data bus |

## Verification
The hardest situation to reach is a user who keeps `strobe` high past the end of an operation. A short request has to complete and the block has to return to idle while the request line was never seen low. The bench reaches it with a directed sequence: it accepts a character write, then keeps stepping ticks well beyond the 8-tick latency before releasing `strobe`. Random requests also change `cmd` and `char_in` right after acceptance and release `strobe` after a random number of ticks, which exercises capture-once behaviour and the timing of the rearm.

// File: rtl/lcd_ctrl_pkg.sv
// Package: shared types and constants for the character LCD controller.
// Assumes an 8-bit display bus and a fixed four-step power-up program.
package lcd_ctrl_pkg;

    localparam int BUS_W    = 8;
    localparam int INIT_LEN = 4;
    localparam int INIT_IW  = $clog2(INIT_LEN);

    typedef enum logic [2:0] {
        ST_LOAD, ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_CHAR = 2'b00, CMD_CLEAR = 2'b01, CMD_BACK = 2'b10, CMD_HOME = 2'b11
    } user_cmd_t;

    // One display write: register select, bus byte and long-wait flag.
    typedef struct packed {
        logic             rs;
        logic [BUS_W-1:0] db;
        logic             long_wait;
    } lcd_word_t;

    // Power-up program step: mode, display on, entry mode, then clear.
    function automatic lcd_word_t init_word(input logic [INIT_IW-1:0] idx);
        lcd_word_t w;
        w.rs = 1'b0;
        w.long_wait = 1'b0;
        case (idx)
            2'd0:    w.db = 8'h30;
            2'd1:    w.db = 8'h0C;
            2'd2:    w.db = 8'h06;
            default: begin w.db = 8'h01; w.long_wait = 1'b1; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/lcd_req_arbiter.sv
// Module: user-side handshake. It detects a fresh strobe on a tick while
// the sequencer is idle and produces ready. Assumes strobe is stable
// around tick edges (synchronised upstream if asynchronous).
module lcd_req_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic strobe,
    input  logic idle,
    output logic accept,
    output logic ready
);
    logic armed;

    assign accept = tick && idle && armed && strobe;
    assign ready  = idle && armed;

    // Arm on a low strobe; disarm on accept or a high strobe while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (tick) begin
            if (!strobe)
                armed <= 1'b1;
            else if (!idle || accept)
                armed <= 1'b0;
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready); // R2
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && strobe && !idle) |=> !ready); // R8

endmodule

// File: rtl/lcd_instr_decode.sv
// Module: maps a user command and character to a display write.
// Pure combinational; assumes the command encoding in lcd_ctrl_pkg.
module lcd_instr_decode
    import lcd_ctrl_pkg::*;
(
    input  logic [1:0]       cmd,
    input  logic [BUS_W-1:0] char_in,
    output lcd_word_t        word
);
    // Select RS level, bus byte and wait class per command.
    always_comb begin
        word.rs        = 1'b0;
        word.db        = 8'h00;
        word.long_wait = 1'b0;
        case (user_cmd_t'(cmd))
            CMD_CHAR:  begin word.rs = 1'b1; word.db = char_in; end
            CMD_CLEAR: begin word.db = 8'h01; word.long_wait = 1'b1; end
            CMD_BACK:  begin word.db = 8'h10; end
            default:   begin word.db = 8'h02; word.long_wait = 1'b1; end
        endcase
    end

endmodule

// File: rtl/lcd_wait_timer.sv
// Module: execution wait counter in ticks. Loaded at the hold step with
// the short or long count minus one; done when it reaches zero.
module lcd_wait_timer #(
    parameter int SHORT_WAIT = 4,
    parameter int LONG_WAIT  = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic long_sel,
    output logic done
);
    localparam int CNT_W = $clog2(LONG_WAIT);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_WAIT - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_WAIT - 1);

    logic [CNT_W-1:0] cnt;

    assign done = (cnt == '0);

    // Load on start, count down on each running tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= long_sel ? LONG_LD : SHORT_LD;
        else if (run && !done)
            cnt <= cnt - 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LONG_LD); // R7

endmodule

// File: rtl/lcd_handshake_ctrl.sv
// Module: top of the character LCD controller. Runs the power-up program,
// then serves one user request per handshake. Each write is SETUP (bus
// valid, E low), PULSE (E high), HOLD (E low), then WAIT. All steps
// advance on tick only.
module lcd_handshake_ctrl
    import lcd_ctrl_pkg::*;
#(
    parameter int SHORT_WAIT = 4,
    parameter int LONG_WAIT  = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             strobe,
    input  logic [1:0]       cmd,
    input  logic [BUS_W-1:0] char_in,
    output logic             ready,
    output logic             lcd_rs,
    output logic             lcd_e,
    output logic             lcd_rw,
    output logic [BUS_W-1:0] lcd_db
);
    localparam logic [INIT_IW-1:0] INIT_LAST = INIT_IW'(INIT_LEN - 1);

    seq_state_t         state;
    logic [INIT_IW-1:0] init_idx;
    logic               in_init;
    logic               long_q;
    logic               accept;
    logic               wait_done;
    lcd_word_t          user_word;
    lcd_word_t          boot_word;

    assign lcd_rw    = 1'b0;
    assign boot_word = init_word(init_idx);

    lcd_req_arbiter u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .strobe (strobe),
        .idle   (state == ST_IDLE),
        .accept (accept),
        .ready  (ready)
    );

    lcd_instr_decode u_dec (
        .cmd     (cmd),
        .char_in (char_in),
        .word    (user_word)
    );

    lcd_wait_timer #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tick && state == ST_HOLD),
        .run      (tick && state == ST_WAIT),
        .long_sel (long_q),
        .done     (wait_done)
    );

    // Write sequencer: owns the state, the bus registers and the E flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_LOAD;
            init_idx <= '0;
            in_init  <= 1'b1;
            lcd_rs   <= 1'b0;
            lcd_db   <= '0;
            long_q   <= 1'b0;
            lcd_e    <= 1'b0;
        end else if (tick) begin
            case (state)
                ST_LOAD: begin
                    lcd_rs <= boot_word.rs;
                    lcd_db <= boot_word.db;
                    long_q <= boot_word.long_wait;
                    state  <= ST_SETUP;
                end
                ST_IDLE: begin
                    if (accept) begin
                        lcd_rs <= user_word.rs;
                        lcd_db <= user_word.db;
                        long_q <= user_word.long_wait;
                        state  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    lcd_e <= 1'b1;
                    state <= ST_PULSE;
                end
                ST_PULSE: begin
                    lcd_e <= 1'b0;
                    state <= ST_HOLD;
                end
                ST_HOLD: state <= ST_WAIT;
                ST_WAIT: begin
                    if (wait_done) begin
                        if (in_init && init_idx != INIT_LAST) begin
                            init_idx <= init_idx + 1'b1;
                            state    <= ST_LOAD;
                        end else begin
                            in_init <= 1'b0;
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_E_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && tick) |=> !lcd_e); // R6
    AST_RS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lcd_rs) |-> (!lcd_e && !$past(lcd_e))); // R6
    AST_DB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> $stable(lcd_db)); // R6
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !lcd_e); // R2

endmodule

// File: tb/lcd_handshake_ctrl_bench.sv
// Bench: steps tick one pulse at a time and samples on the falling clock
// edge. A monitor records every E pulse and checks RS/bus spacing.
module lcd_handshake_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       strobe = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [7:0] char_in = 8'h00;
    logic       ready, lcd_rs, lcd_e, lcd_rw;
    logic [7:0] lcd_db;

    int vectors = 0;
    int miscompares = 0;
    int n_wr = 0;
    logic       wr_rs [0:7];
    logic [7:0] wr_db [0:7];
    logic       prev_e = 1'b0, prev_rs = 1'b0;
    logic [7:0] prev_db = 8'h00;

    always #4 clk = ~clk;

    lcd_handshake_ctrl u_lcd_handshake_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .strobe(strobe), .cmd(cmd),
        .char_in(char_in), .ready(ready), .lcd_rs(lcd_rs), .lcd_e(lcd_e),
        .lcd_rw(lcd_rw), .lcd_db(lcd_db)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_rs(input logic [1:0] c);
        return c == 2'b00;
    endfunction
    function automatic logic [7:0] exp_db(input logic [1:0] c, input logic [7:0] d);
        case (c)
            2'b00:   return d;
            2'b01:   return 8'h01;
            2'b10:   return 8'h10;
            default: return 8'h02;
        endcase
    endfunction
    function automatic int exp_lat(input logic [1:0] c);
        return (c == 2'b01 || c == 2'b11) ? 164 : 8;
    endfunction

    // One tick pulse, then sample outputs and run the spacing monitor.
    task automatic step();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        if (lcd_e) begin
            chk(!prev_e, "R6 E one tick", 1, 0);
            chk(lcd_rs == prev_rs && lcd_db == prev_db, "R6 setup",
                {lcd_rs, lcd_db}, {prev_rs, prev_db});
            if (n_wr < 8) begin wr_rs[n_wr] = lcd_rs; wr_db[n_wr] = lcd_db; end
            n_wr++;
        end else if (prev_e) begin
            chk(lcd_rs == prev_rs && lcd_db == prev_db, "R6 hold",
                {lcd_rs, lcd_db}, {prev_rs, prev_db});
        end
        chk(!lcd_rw, "R10 rw low", lcd_rw, 0);
        prev_e = lcd_e; prev_rs = lcd_rs; prev_db = lcd_db;
    endtask

    // One full handshake; strobe released after rel ticks, inputs scrambled.
    task automatic run_op(input logic [1:0] c, input logic [7:0] d, input int rel);
        int k;
        n_wr = 0;
        cmd = c; char_in = d; strobe = 1'b1;
        step();
        k = 1;
        chk(!ready, "R2 ready drop", ready, 0);
        cmd = ~c; char_in = ~d;
        for (int i = 0; i < rel; i++) begin step(); k++; end
        strobe = 1'b0;
        while (!ready && k < 400) begin step(); k++; end
        chk(k == exp_lat(c), "R7 latency", k, exp_lat(c));
        chk(n_wr == 1, "R1 one write", n_wr, 1);
        chk(wr_rs[0] == exp_rs(c), c == 2'b00 ? "R3 rs" : "R4 rs",
            wr_rs[0], exp_rs(c));
        chk(wr_db[0] == exp_db(c, d), c == 2'b00 ? "R3 R9 db" : "R4 R9 db",
            wr_db[0], exp_db(c, d));
    endtask

    initial begin
        #(8 * 190000);
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int k;
        logic [7:0] seq [0:3];
        void'($urandom(32'd467));
        seq[0] = 8'h30; seq[1] = 8'h0C; seq[2] = 8'h06; seq[3] = 8'h01;
        repeat (3) @(negedge clk);
        chk(!ready && !lcd_e, "R5 reset state", {ready, lcd_e}, 0);
        rst_n = 1'b1;
        // R5: power-up program and its duration.
        k = 0;
        while (!ready && k < 400) begin step(); k++; end
        chk(k == 188, "R5 init ticks", k, 188);
        chk(n_wr == 4, "R5 init count", n_wr, 4);
        for (int i = 0; i < 4; i++)
            chk(wr_rs[i] == 1'b0 && wr_db[i] == seq[i], "R5 init word",
                {wr_rs[i], wr_db[i]}, {1'b0, seq[i]});
        // Directed: every command once, including boundary bytes.
        run_op(2'b00, 8'h00, 0);
        run_op(2'b00, 8'hFF, 2);
        run_op(2'b01, 8'h5A, 1);
        run_op(2'b10, 8'hA5, 0);
        run_op(2'b11, 8'h33, 3);
        // R8: strobe held high past the end of a character write.
        n_wr = 0;
        cmd = 2'b00; char_in = 8'h41; strobe = 1'b1;
        for (int i = 0; i < 30; i++) step();
        chk(!ready, "R8 held strobe ready", ready, 0);
        chk(n_wr == 1, "R8 no retrigger", n_wr, 1);
        strobe = 1'b0;
        step();
        chk(ready, "R8 rearm", ready, 1);
        // Constrained random requests.
        for (int i = 0; i < 30; i++)
            run_op(2'($urandom), 8'($urandom), int'($urandom % 3));
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule